// File: doc/BRIEF.md
# Streaming Piecewise Contrast Stretch Unit

This block enhances the contrast of 8-bit grayscale video delivered as a pixel stream. It applies a programmable piecewise-linear grey-level transfer function to every pixel. The stream is qualified by frame-valid, line-valid and data-valid strobes. The input grey scale is divided into segments by programmable breakpoints. Each segment has its own output base level and fixed-point slope, so a narrow band of input levels can be spread over a wider output range. The block takes one pixel per clock. Each output pixel comes out exactly two cycles later, and the three qualifiers are delayed by the same two cycles so they stay aligned with the pixel data.

Alongside the datapath, the block checks the stream against a fixed raster of `LINE_PIXELS` pixels per line and `FRAME_LINES` lines per frame. The defaults are 3008 pixels and 2000 lines, with line and column indices counting from 0. It keeps a per-line pixel counter, a line counter and a frame counter. A small register slave lets a host read and load the frame and line counters and program the segment table. A sticky raster-error output flags any line whose length does not match the nominal raster.

Top module: `contrast_stretch_top`

## Requirements
- R1: After reset, all stream outputs, `raster_err`, `bus_rdata`, the frame counter and the line counter are 0. Segment k holds start level k*256/NSEG, base level k*256/NSEG and slope 0x0100 (unity), so the default transfer function is the identity.
- R2: `out_fval`, `out_lval` and `out_dval` equal `in_fval`, `in_lval` and `in_dval` from two clock edges earlier. `out_pix` is the transform of the `in_pix` sampled at that same edge.
- R3: A pixel uses the highest-numbered segment whose start level is less than or equal to the pixel value. A pixel below the start level of segment 0 uses segment 0 with an offset of zero, so the output is segment 0's base level.
- R4: The output is base + ((pixel − start) × slope) >> 8. The slope is an unsigned 8.8 fixed-point value and the shifted product is truncated.
- R5: Any result above 255 saturates to 255.
- R6: A pixel is accepted only on an edge where `in_lval` and `in_dval` are both 1. The pixel counter restarts at each rising edge of `in_lval`, so gaps in `in_dval` do not disturb the count.
- R7: The line counter is cleared on a rising edge of `in_fval` and increments on each falling edge of `in_lval`. It is read at address 1.
- R8: The frame counter increments when the pixel at line FRAME_LINES−1, column LINE_PIXELS−1 is accepted, but only if `raster_err` is clear. It is read at address 0.
- R9: `raster_err` sets when `in_lval` falls after a number of accepted pixels other than LINE_PIXELS. It stays set until the next rising edge of `in_fval` clears it.
- R10: A bus write to address 0 or 1 loads the frame or line counter, and takes priority over the counter's own update. A write to address 4+k loads segment k with start level in bits [7:0], base level in bits [15:8] and slope in bits [31:16]. A read returns the register on `bus_rdata` on the edge after `bus_rd`, and `bus_rdata` holds its value while `bus_rd` is low.
- R11: Writes to addresses outside 0, 1 and 4..4+NSEG−1 change no register. Reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_fval | input | 1 | Input frame-valid |
| in_lval | input | 1 | Input line-valid |
| in_dval | input | 1 | Input data-valid |
| in_pix | input | 8 | Input grey level |
| out_fval | output | 1 | Frame-valid delayed two cycles |
| out_lval | output | 1 | Line-valid delayed two cycles |
| out_dval | output | 1 | Data-valid delayed two cycles |
| out_pix | output | 8 | Transformed grey level |
| raster_err | output | 1 | Sticky wrong-line-length flag |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench places pixels exactly on segment start levels and one level below them. A selector using a strict comparison, or picking the lowest matching segment, would map those pixels with the wrong base. It drives values whose products cross 255 to catch wraparound where saturation is required, and it drives a value below the first breakpoint to catch a negative offset wrapping to a large one. It sends lines with data-valid gaps and a line one pixel short. A counter that counted idle cycles, or did not restart on line-valid, would raise a false error or miss the real one, and the frame counter would step when it must not. Each pixel and qualifier is compared two cycles after it enters, so any pipeline stage lost or duplicated on a single signal shows up as a misaligned stream.

// File: rtl/csu_pkg.sv
package csu_pkg;

    localparam int PIX_W        = 8;
    localparam int BUS_W        = 32;
    localparam int SLOPE_W      = 16;
    localparam int REG_FRAME    = 0;
    localparam int REG_LINE     = 1;
    localparam int REG_SEG_BASE = 4;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        logic [SLOPE_W-1:0] slope;
        pix_t               y0;
        pix_t               x0;
    } seg_cfg_t;

    typedef struct packed {
        logic fval;
        logic lval;
        logic dval;
    } qual_t;

    typedef struct packed {
        qual_t              q;
        pix_t               diff;
        logic [SLOPE_W-1:0] slope;
        pix_t               y0;
    } map_s1_t;

    function automatic pix_t seg_apply(pix_t diff, logic [SLOPE_W-1:0] slope, pix_t y0);
        logic [PIX_W+SLOPE_W-1:0] prod;
        logic [SLOPE_W:0]         sum;
        prod = (PIX_W+SLOPE_W)'(diff) * (PIX_W+SLOPE_W)'(slope);
        sum  = (SLOPE_W+1)'(y0) + (SLOPE_W+1)'(prod[PIX_W+SLOPE_W-1:8]);
        return (sum > (SLOPE_W+1)'(255)) ? pix_t'(8'hFF) : sum[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/csu_raster.sv
module csu_raster
    import csu_pkg::*;
#(
    parameter int LINE_PIXELS = 3008,
    parameter int FRAME_LINES = 2000,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  qual_t            q_in,
    input  logic             wr_frame,
    input  logic             wr_line,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] frame_cnt,
    output logic [CNT_W-1:0] line_cnt,
    output logic             raster_err
);
    localparam int PC_W = $clog2(LINE_PIXELS + 1) + 1;
    localparam logic [PC_W-1:0]  PIX_LAST  = PC_W'(LINE_PIXELS - 1);
    localparam logic [PC_W-1:0]  PIX_NOM   = PC_W'(LINE_PIXELS);
    localparam logic [CNT_W-1:0] LINE_LAST = CNT_W'(FRAME_LINES - 1);

    logic            lval_q, fval_q;
    logic [PC_W-1:0] pix_cnt, idx;
    logic            line_start, line_end, frame_start, accept, last_pix;

    always_comb begin
        line_start  = q_in.lval & ~lval_q;
        line_end    = ~q_in.lval & lval_q;
        frame_start = q_in.fval & ~fval_q;
        accept      = q_in.lval & q_in.dval;
        idx         = line_start ? '0 : pix_cnt;
        last_pix    = accept && (idx == PIX_LAST) && (line_cnt == LINE_LAST) && !raster_err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lval_q     <= 1'b0;
            fval_q     <= 1'b0;
            pix_cnt    <= '0;
            line_cnt   <= '0;
            frame_cnt  <= '0;
            raster_err <= 1'b0;
        end else begin
            lval_q <= q_in.lval;
            fval_q <= q_in.fval;

            if (accept) begin
                if (idx != '1) pix_cnt <= idx + 1'b1;
                else           pix_cnt <= idx;
            end else if (line_start) begin
                pix_cnt <= '0;
            end

            if (frame_start)                         raster_err <= 1'b0;
            else if (line_end && pix_cnt != PIX_NOM) raster_err <= 1'b1;

            if (wr_line)          line_cnt <= wdata;
            else if (frame_start) line_cnt <= '0;
            else if (line_end)    line_cnt <= line_cnt + 1'b1;

            if (wr_frame)      frame_cnt <= wdata;
            else if (last_pix) frame_cnt <= frame_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/csu_regs.sv
module csu_regs
    import csu_pkg::*;
#(
    parameter int NSEG   = 4,
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic                      bus_wr,
    input  logic                      bus_rd,
    input  logic [BUS_W-1:0]          bus_wdata,
    input  logic [CNT_W-1:0]          frame_cnt,
    input  logic [CNT_W-1:0]          line_cnt,
    output logic [BUS_W-1:0]          bus_rdata,
    output seg_cfg_t [NSEG-1:0]       cfg,
    output logic                      wr_frame,
    output logic                      wr_line
);
    localparam int SEG_END = REG_SEG_BASE + NSEG;

    logic [BUS_W-1:0] rd_mux;

    assign wr_frame = bus_wr && (int'(bus_addr) == REG_FRAME);
    assign wr_line  = bus_wr && (int'(bus_addr) == REG_LINE);

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        localparam logic [PIX_W-1:0] DEF_LVL = PIX_W'((k * 256) / NSEG);
        always_ff @(posedge clk) begin
            if (rst) begin
                cfg[k].x0    <= DEF_LVL;
                cfg[k].y0    <= DEF_LVL;
                cfg[k].slope <= SLOPE_W'(16'h0100);
            end else if (bus_wr && int'(bus_addr) == REG_SEG_BASE + k) begin
                cfg[k] <= seg_cfg_t'(bus_wdata);
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (int'(bus_addr) == REG_FRAME) begin
            rd_mux = BUS_W'(frame_cnt);
        end else if (int'(bus_addr) == REG_LINE) begin
            rd_mux = BUS_W'(line_cnt);
        end else begin
            for (int k = 0; k < NSEG; k++) begin
                if (int'(bus_addr) == REG_SEG_BASE + k) rd_mux = BUS_W'(cfg[k]);
            end
        end
        if (int'(bus_addr) >= SEG_END) rd_mux = '0;
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end
endmodule

// File: rtl/csu_map.sv
module csu_map
    import csu_pkg::*;
#(
    parameter int NSEG = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  qual_t               q_in,
    input  pix_t                pix_in,
    input  seg_cfg_t [NSEG-1:0] cfg,
    output qual_t               q_out,
    output pix_t                pix_out
);
    localparam int SEL_W = (NSEG > 1) ? $clog2(NSEG) : 1;

    logic [SEL_W-1:0] sel;
    map_s1_t          s1_d, s1_q;

    always_comb begin
        sel = '0;
        for (int k = 1; k < NSEG; k++) begin
            if (pix_in >= cfg[k].x0) sel = SEL_W'(k);
        end
        s1_d.q     = q_in;
        s1_d.slope = cfg[sel].slope;
        s1_d.y0    = cfg[sel].y0;
        s1_d.diff  = (pix_in >= cfg[sel].x0) ? pix_t'(pix_in - cfg[sel].x0) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q    <= '0;
            q_out   <= '0;
            pix_out <= '0;
        end else begin
            s1_q    <= s1_d;
            q_out   <= s1_q.q;
            pix_out <= seg_apply(s1_q.diff, s1_q.slope, s1_q.y0);
        end
    end
endmodule

// File: rtl/contrast_stretch_top.sv
module contrast_stretch_top
    import csu_pkg::*;
#(
    parameter int LINE_PIXELS = 3008,
    parameter int FRAME_LINES = 2000,
    parameter int NSEG        = 4,
    parameter int ADDR_W      = 4,
    parameter int CNT_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_fval,
    input  logic              in_lval,
    input  logic              in_dval,
    input  logic [7:0]        in_pix,
    output logic              out_fval,
    output logic              out_lval,
    output logic              out_dval,
    output logic [7:0]        out_pix,
    output logic              raster_err,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    qual_t               q_in, q_out;
    seg_cfg_t [NSEG-1:0] cfg;
    logic [CNT_W-1:0]    frame_cnt, line_cnt;
    logic                wr_frame, wr_line;

    assign q_in = '{fval: in_fval, lval: in_lval, dval: in_dval};
    assign out_fval = q_out.fval;
    assign out_lval = q_out.lval;
    assign out_dval = q_out.dval;

    csu_map #(.NSEG(NSEG)) map_i (
        .clk(clk), .rst(rst), .q_in(q_in), .pix_in(in_pix),
        .cfg(cfg), .q_out(q_out), .pix_out(out_pix)
    );

    csu_raster #(.LINE_PIXELS(LINE_PIXELS), .FRAME_LINES(FRAME_LINES), .CNT_W(CNT_W)) raster_i (
        .clk(clk), .rst(rst), .q_in(q_in), .wr_frame(wr_frame), .wr_line(wr_line),
        .wdata(bus_wdata[CNT_W-1:0]), .frame_cnt(frame_cnt), .line_cnt(line_cnt),
        .raster_err(raster_err)
    );

    csu_regs #(.NSEG(NSEG), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .frame_cnt(frame_cnt), .line_cnt(line_cnt),
        .bus_rdata(bus_rdata), .cfg(cfg), .wr_frame(wr_frame), .wr_line(wr_line)
    );
endmodule

// File: rtl/csu_checker.sv
module csu_checker #(
    parameter int ADDR_W = 4,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_fval,
    input logic              in_lval,
    input logic              in_dval,
    input logic              out_fval,
    input logic              out_lval,
    input logic              out_dval,
    input logic              raster_err,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [31:0]       bus_rdata,
    input logic [CNT_W-1:0]  frame_cnt,
    input logic [CNT_W-1:0]  line_cnt
);
    logic [1:0] age;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst)            age <= '0;
        else if (age != 2'd3) age <= age + 1'b1;
    end
    assign warm = (age == 2'd3);

    AST_QUAL_LATENCY: assert property (@(posedge clk) disable iff (rst)
        warm |-> ({out_fval, out_lval, out_dval} == $past({in_fval, in_lval, in_dval}, 2))) else $error("qualifier latency"); // R2

    AST_LINE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (warm && in_fval && !$past(in_fval) && !(bus_wr && bus_addr == ADDR_W'(1))) |=> (line_cnt == '0)) else $error("line clear"); // R7

    AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
        (warm && !(bus_wr && bus_addr == ADDR_W'(0))) |=> (frame_cnt == $past(frame_cnt) || frame_cnt == $past(frame_cnt) + 1'b1)) else $error("frame step"); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        (warm && raster_err && !(in_fval && !$past(in_fval))) |=> raster_err) else $error("err sticky"); // R9

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (warm && in_fval && !$past(in_fval)) |=> !raster_err) else $error("err clear"); // R9

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (warm && !bus_rd) |=> $stable(bus_rdata)) else $error("rdata hold"); // R10
endmodule

bind contrast_stretch_top csu_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst(rst), .in_fval(in_fval), .in_lval(in_lval), .in_dval(in_dval),
    .out_fval(out_fval), .out_lval(out_lval), .out_dval(out_dval),
    .raster_err(raster_err), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .frame_cnt(frame_cnt), .line_cnt(line_cnt)
);

// File: tb/contrast_stretch_top_tb.sv
module contrast_stretch_top_tb_top;
    localparam int LP = 8;
    localparam int FL = 3;
    localparam int NS = 4;
    localparam int AW = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_fval = 0, in_lval = 0, in_dval = 0;
    logic [7:0]  in_pix = '0;
    logic        out_fval, out_lval, out_dval, raster_err;
    logic [7:0]  out_pix;
    logic [AW-1:0] bus_addr = '0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = '0, bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_en = 0;

    logic [7:0]  sx0 [NS];
    logic [7:0]  sy0 [NS];
    logic [15:0] ssl [NS];
    logic [11:0] h1, h2;

    always #5 clk = ~clk;

    contrast_stretch_top #(.LINE_PIXELS(LP), .FRAME_LINES(FL), .NSEG(NS), .ADDR_W(AW), .CNT_W(16)) dut_i (
        .clk(clk), .rst(rst), .in_fval(in_fval), .in_lval(in_lval), .in_dval(in_dval),
        .in_pix(in_pix), .out_fval(out_fval), .out_lval(out_lval), .out_dval(out_dval),
        .out_pix(out_pix), .raster_err(raster_err), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] ref_map(logic [7:0] p);
        int s = 0;
        int r;
        for (int k = 1; k < NS; k++) if (p >= sx0[k]) s = k;
        if (p < sx0[s]) r = sy0[s];
        else r = sy0[s] + (((p - sx0[s]) * ssl[s]) >> 8);
        return (r > 255) ? 8'hFF : r[7:0];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // reference two-stage model of the stream (R2, R4)
    always @(posedge clk) begin
        h1 <= {in_fval, in_lval, in_dval, in_lval & in_dval, ref_map(in_pix)};
        h2 <= h1;
    end

    always @(negedge clk) begin
        if (mon_en) begin
            check("R2 qualifiers", {29'd0, out_fval, out_lval, out_dval}, {29'd0, h2[11:9]});
            if (h2[8]) check("R4 stream pixel", {24'd0, out_pix}, {24'd0, h2[7:0]});
        end
    end

    task automatic bus_write(int a, logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1;
        if (a >= 4 && a < 4 + NS) begin
            sx0[a-4] = d[7:0]; sy0[a-4] = d[15:8]; ssl[a-4] = d[31:16];
        end
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic bus_read(int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic send_line(int npix, bit gaps, int seed);
        @(negedge clk);
        in_lval = 1;
        for (int i = 0; i < npix; i++) begin
            if (gaps) begin
                in_dval = 0; in_pix = 8'hAA;
                @(negedge clk);
            end
            in_dval = 1; in_pix = 8'((seed * 37 + i * 29 + 11) & 255);
            @(negedge clk);
        end
        in_dval = 0; in_lval = 0; in_pix = 0;
    endtask

    task automatic send_frame(int short_line, bit gaps);
        @(negedge clk);
        in_fval = 1;
        for (int l = 0; l < FL; l++) send_line((l == short_line) ? LP - 1 : LP, gaps, l);
        @(negedge clk);
        in_fval = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic one_pixel(logic [7:0] p, logic [7:0] exp, string req);
        @(negedge clk);
        in_fval = 1; in_lval = 1; in_dval = 1; in_pix = p;
        @(negedge clk);
        in_fval = 0; in_lval = 0; in_dval = 0; in_pix = 0;
        @(negedge clk);
        check(req, {24'd0, out_pix}, {24'd0, exp});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 out qualifiers", {29'd0, out_fval, out_lval, out_dval}, 32'd0);
        check("R1 out_pix", {24'd0, out_pix}, 32'd0);
        check("R1 raster_err", {31'd0, raster_err}, 32'd0);
        check("R1 rdata", bus_rdata, 32'd0);
        bus_read(0, d); check("R1 frame counter", d, 32'd0);
        bus_read(1, d); check("R1 line counter", d, 32'd0);
        for (int k = 0; k < NS; k++) begin
            bus_read(4 + k, d);
            check("R1 segment default", d, {16'h0100, 8'(k * 64), 8'(k * 64)});
        end
    endtask

    task automatic t_bus();
        logic [31:0] d, d2;
        bus_write(0, 32'h1234); bus_read(0, d); check("R10 frame load", d, 32'h1234);
        bus_write(1, 32'h0005); bus_read(1, d); check("R10 line load", d, 32'h5);
        bus_write(6, 32'h0180_9060); bus_read(6, d); check("R10 segment load", d, 32'h0180_9060);
        d2 = bus_rdata;
        repeat (3) @(negedge clk);
        check("R10 rdata hold", bus_rdata, d2);
        bus_write(2, 32'hDEAD_BEEF); bus_write(3, 32'hDEAD_BEEF); bus_write(4 + NS, 32'hDEAD_BEEF);
        bus_read(2, d); check("R11 unmapped read 2", d, 0);
        bus_read(4 + NS, d); check("R11 unmapped read top", d, 0);
        bus_read(0, d); check("R11 frame untouched", d, 32'h1234);
        bus_read(1, d); check("R11 line untouched", d, 32'h5);
        for (int k = 0; k < NS; k++) begin
            bus_read(4 + k, d);
            check("R11 segment untouched", d, {ssl[k], sy0[k], sx0[k]});
        end
        bus_write(6, {16'h0100, 8'd128, 8'd128});
        bus_write(0, 0); bus_write(1, 0);
    endtask

    task automatic t_frames();
        logic [31:0] d;
        send_frame(-1, 0);
        bus_read(0, d); check("R8 frame after clean frame", d, 1);
        bus_read(1, d); check("R7 line count after frame", d, FL);
        check("R9 no error on clean frame", {31'd0, raster_err}, 0);
        send_frame(-1, 1);
        bus_read(0, d); check("R6 frame with dval gaps", d, 2);
        check("R6 no error with gaps", {31'd0, raster_err}, 0);
        send_frame(0, 0);
        check("R9 error on short line", {31'd0, raster_err}, 1);
        bus_read(0, d); check("R8 no step on bad frame", d, 2);
        @(negedge clk); in_fval = 1;
        @(negedge clk);
        check("R9 error cleared by frame start", {31'd0, raster_err}, 0);
        bus_read(1, d); check("R7 line cleared by frame start", d, 0);
        for (int l = 0; l < FL; l++) send_line(LP, 0, l + 5);
        @(negedge clk); in_fval = 0;
        repeat (3) @(negedge clk);
        bus_read(0, d); check("R8 frame after recovery", d, 3);
    endtask

    task automatic t_segments();
        bus_write(4, {16'h0080, 8'd0,   8'd0});
        bus_write(5, {16'h0300, 8'd25,  8'd50});
        bus_write(6, {16'h0100, 8'd175, 8'd100});
        bus_write(7, {16'h0400, 8'd240, 8'd200});
        one_pixel(8'd0,   8'd0,   "R3 level 0");
        one_pixel(8'd49,  8'd24,  "R4 truncation seg0");
        one_pixel(8'd50,  8'd25,  "R3 breakpoint 50");
        one_pixel(8'd99,  8'd172, "R4 seg1 top");
        one_pixel(8'd100, 8'd175, "R3 breakpoint 100");
        one_pixel(8'd150, 8'd225, "R4 seg2 mid");
        one_pixel(8'd199, 8'd255, "R5 saturate seg2");
        one_pixel(8'd200, 8'd240, "R3 breakpoint 200");
        one_pixel(8'd203, 8'd252, "R4 seg3 below limit");
        one_pixel(8'd204, 8'd255, "R5 saturate at 256");
        one_pixel(8'd255, 8'd255, "R5 saturate top");
        bus_write(4, {16'h0080, 8'd30, 8'd20});
        one_pixel(8'd5,   8'd30,  "R3 below first breakpoint");
        one_pixel(8'd20,  8'd30,  "R3 first breakpoint");
        one_pixel(8'd48,  8'd44,  "R4 seg0 offset");
        send_frame(-1, 0);
    endtask

    initial begin
        for (int k = 0; k < NS; k++) begin
            sx0[k] = 8'(k * 64); sy0[k] = 8'(k * 64); ssl[k] = 16'h0100;
        end
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        mon_en = 1;
        t_bus();
        t_frames();
        t_segments();
        repeat (4) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule